// File: doc/BRIEF.md
# Cycle Counter with Postscaled Sampling Events

This block keeps a free-running up-counter of core clock cycles and turns it into periodic events for a trace or profiling path. One of two low-order counter bits is watched. Every change of that bit, in either direction, is a tap. A reloadable 4-bit postscaler thins the taps, so an event occurs on one tap out of every N+1, where N is the programmed preset.

Each postscaler event goes to one of two outputs. If periodic sampling is on, it goes to the sample pulse. If sampling is off and the cycle-event enable is set, it goes to the cycle-event pulse. A separate, slower tap on one of three high-order counter bits produces synchronization pulses, gated by an external enable. When the block is built without the counter, the run bit cannot be set and the count stays at zero.

A small register port gives access to the settings, the count, a postscaler readback and an instruction-address sample. The address sample shows all ones while the core is halted.

Top module: `cyc_sampler_top`

## Requirements
- R1: While the run bit is set and `core_halted` is low, the count rises by one every clock and wraps from all ones to zero. While `core_halted` is high, the count holds.
- R2: Register address 1 reads and writes the count. A write in the same cycle as an increment wins: the count after the edge equals the written value.
- R3: Settings register bit 3 selects the watched bit: 0 selects count bit 6, 1 selects count bit 10. A rise or a fall of the watched bit caused by an increment is one tap.
- R4: Settings register bits 11:8 hold the preset. Each write to address 0 loads the postscaler with the written preset. On a tap, a non-zero postscaler decrements. A zero postscaler fires an event and reloads the preset, so there is one event per preset+1 taps. Bits 15:12 of address 0 read the postscaler's current value, and writes to those bits are ignored.
- R5: Settings register bit 1 enables sampling and bit 2 enables cycle events. With bit 1 set, every event goes to `sample_pulse` and `cycevt_pulse` stays low. `cycevt_pulse` fires only when bit 1 is clear and bit 2 is set.
- R6: Settings register bits 5:4 select the sync tap: 0 is off, 1 is count bit 24, 2 is bit 26, 3 is bit 28. `sync_pulse` fires on either edge of the selected bit, only on an increment, and only while `sync_allow` is high.
- R7: With `HAS_COUNTER` = 0, settings register bit 0 (run) always reads 0, writes to it are ignored, and the count stays 0.
- R8: Register address 2 reads all ones while `core_halted` is high, and otherwise reads `inst_addr`.
- R9: Each of `sample_pulse`, `cycevt_pulse` and `sync_pulse` is a one-cycle pulse. It is registered on the same edge as the count update that caused it.
- R10: After reset, the settings register, the count, the postscaler and all pulse outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| core_halted | input | 1 | Core is halted; freezes the count |
| inst_addr | input | 32 | Current instruction address |
| sync_allow | input | 1 | External enable for sync pulses |
| reg_addr | input | 2 | Register select: 0 settings, 1 count, 2 address sample, 3 reads zero |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| sample_pulse | output | 1 | Periodic sample event |
| cycevt_pulse | output | 1 | Cycle-count event |
| sync_pulse | output | 1 | Synchronization pulse from the high-order tap |

## Verification
The bench builds two instances from the same stimulus. One uses the default parameters, a 32-bit counter with the counter present. The other has `HAS_COUNTER` = 0, so the check that the run bit cannot be set is made at the register port. The count is writable, so the bench preloads it a few cycles short of a bit-24 or bit-28 edge. That puts the sync taps and the counter wrap within reach in a handful of cycles instead of millions. The rate tests count pulses over windows of 512 and 2048 cycles, which covers both rising and falling taps.

// File: rtl/cyc_sampler_pkg.sv
package cyc_sampler_pkg;

    localparam int unsigned REG_W = 32;
    localparam int unsigned PS_W  = 4;

    localparam int unsigned CF_RUN    = 0;
    localparam int unsigned CF_SAMPLE = 1;
    localparam int unsigned CF_CYCEVT = 2;
    localparam int unsigned CF_TAPHI  = 3;
    localparam int unsigned CF_SYNC   = 4;
    localparam int unsigned CF_PRESET = 8;
    localparam int unsigned CF_PSVAL  = 12;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_COUNT  = 2'd1,
        REG_PCSAMP = 2'd2,
        REG_RSVD   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SYNC_OFF = 2'd0,
        SYNC_LO  = 2'd1,
        SYNC_MID = 2'd2,
        SYNC_HI  = 2'd3
    } sync_tap_e;

    typedef struct packed {
        logic [PS_W-1:0] preset;
        sync_tap_e       sync_tap;
        logic            tap_hi;
        logic            cyc_evt_en;
        logic            sample_en;
        logic            run;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w, input logic run_ok);
        ctrl_t c;
        c.run        = w[CF_RUN] & run_ok;
        c.sample_en  = w[CF_SAMPLE];
        c.cyc_evt_en = w[CF_CYCEVT];
        c.tap_hi     = w[CF_TAPHI];
        c.sync_tap   = sync_tap_e'(w[CF_SYNC +: 2]);
        c.preset     = w[CF_PRESET +: PS_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c, input logic [PS_W-1:0] ps);
        logic [REG_W-1:0] w;
        w = '0;
        w[CF_RUN]            = c.run;
        w[CF_SAMPLE]         = c.sample_en;
        w[CF_CYCEVT]         = c.cyc_evt_en;
        w[CF_TAPHI]          = c.tap_hi;
        w[CF_SYNC +: 2]      = c.sync_tap;
        w[CF_PRESET +: PS_W] = c.preset;
        w[CF_PSVAL +: PS_W]  = ps;
        return w;
    endfunction

    // True when an increment of v flips bit b: all bits below b are ones.
    function automatic logic carries_into(input logic [63:0] v, input int unsigned b);
        logic [63:0] m;
        m = (64'd1 << b) - 64'd1;
        return (v & m) == m;
    endfunction

endpackage

// File: rtl/cyc_count_core.sv
module cyc_count_core
    import cyc_sampler_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter bit          HAS_COUNTER = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             halted,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             step
);
    generate
        if (HAS_COUNTER) begin : g_cnt
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst)       cnt_q <= '0;
                else if (ld)   cnt_q <= ld_val;
                else if (run && !halted) cnt_q <= cnt_q + 1'b1;
            end
            assign cnt  = cnt_q;
            assign step = run && !halted && !ld;
        end else begin : g_nocnt
            logic unused_in;
            assign unused_in = ^{clk, rst, run, halted, ld, ld_val};
            assign cnt  = '0;
            assign step = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/cyc_postscaler.sv
module cyc_postscaler
    import cyc_sampler_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned TAP_LO = 6,
    parameter int unsigned TAP_HI = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt,
    input  logic             tap_hi,
    input  logic             preset_ld,
    input  logic [PS_W-1:0]  preset_new,
    input  logic [PS_W-1:0]  preset,
    input  logic             sample_en,
    input  logic             cyc_evt_en,
    output logic [PS_W-1:0]  ps_val,
    output logic             sample_pulse,
    output logic             cycevt_pulse
);
    logic tap_evt;
    assign tap_evt = step && carries_into(64'(cnt), tap_hi ? TAP_HI : TAP_LO);

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_val       <= '0;
            sample_pulse <= 1'b0;
            cycevt_pulse <= 1'b0;
        end else begin
            sample_pulse <= 1'b0;
            cycevt_pulse <= 1'b0;
            if (preset_ld) begin
                ps_val <= preset_new;
            end else if (tap_evt) begin
                if (ps_val == '0) begin
                    ps_val       <= preset;
                    sample_pulse <= sample_en;
                    cycevt_pulse <= !sample_en && cyc_evt_en;
                end else begin
                    ps_val <= ps_val - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cyc_sync_tap.sv
module cyc_sync_tap
    import cyc_sampler_pkg::*;
#(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned SYNC_BASE = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [CNT_W-1:0] cnt,
    input  sync_tap_e        sel,
    input  logic             allow,
    output logic             pulse
);
    int unsigned bit_idx;
    logic        flip;

    always_comb begin
        bit_idx = SYNC_BASE + 2 * ((sel == SYNC_OFF) ? 0 : (int'(sel) - 1));
        flip    = step && allow && (sel != SYNC_OFF) && carries_into(64'(cnt), bit_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= flip;
    end
endmodule

// File: rtl/cyc_sampler_top.sv
module cyc_sampler_top
    import cyc_sampler_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter bit          HAS_COUNTER = 1'b1,
    parameter int unsigned TAP_LO      = 6,
    parameter int unsigned TAP_HI      = 10,
    parameter int unsigned SYNC_BASE   = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        core_halted,
    input  logic [31:0] inst_addr,
    input  logic        sync_allow,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sample_pulse,
    output logic        cycevt_pulse,
    output logic        sync_pulse
);
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    logic             ctrl_wr;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_q;
    logic             step;
    logic [PS_W-1:0]  ps_val;
    reg_sel_e         sel;

    assign sel      = reg_sel_e'(reg_addr);
    assign ctrl_wr  = reg_wr && (sel == REG_CTRL);
    assign cnt_wr   = reg_wr && (sel == REG_COUNT);
    assign ctrl_new = unpack_ctrl(reg_wdata, HAS_COUNTER);

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_new;
    end

    cyc_count_core #(.CNT_W(CNT_W), .HAS_COUNTER(HAS_COUNTER)) u_core (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl_q.run),
        .halted (core_halted),
        .ld     (cnt_wr),
        .ld_val (reg_wdata[CNT_W-1:0]),
        .cnt    (cnt_q),
        .step   (step)
    );

    cyc_postscaler #(.CNT_W(CNT_W), .TAP_LO(TAP_LO), .TAP_HI(TAP_HI)) u_ps (
        .clk          (clk),
        .rst          (rst),
        .step         (step),
        .cnt          (cnt_q),
        .tap_hi       (ctrl_q.tap_hi),
        .preset_ld    (ctrl_wr),
        .preset_new   (ctrl_new.preset),
        .preset       (ctrl_q.preset),
        .sample_en    (ctrl_q.sample_en),
        .cyc_evt_en   (ctrl_q.cyc_evt_en),
        .ps_val       (ps_val),
        .sample_pulse (sample_pulse),
        .cycevt_pulse (cycevt_pulse)
    );

    cyc_sync_tap #(.CNT_W(CNT_W), .SYNC_BASE(SYNC_BASE)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .cnt   (cnt_q),
        .sel   (ctrl_q.sync_tap),
        .allow (sync_allow),
        .pulse (sync_pulse)
    );

    always_comb begin
        case (sel)
            REG_CTRL:   reg_rdata = pack_ctrl(ctrl_q, ps_val);
            REG_COUNT:  reg_rdata = REG_W'(cnt_q);
            REG_PCSAMP: reg_rdata = core_halted ? '1 : inst_addr;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cyc_sampler_chk.sv
module cyc_sampler_chk #(
    parameter int unsigned CNT_W       = 32,
    parameter bit          HAS_COUNTER = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic             halted,
    input logic             run,
    input logic             ld,
    input logic [CNT_W-1:0] cnt,
    input logic [31:0]      wdata,
    input logic             sync_allow,
    input logic [1:0]       reg_addr,
    input logic [31:0]      reg_rdata,
    input logic             sample_pulse,
    input logic             cycevt_pulse,
    input logic             sync_pulse
);
    generate
        if (HAS_COUNTER) begin : g_has
            assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
                (run && !halted && !ld) |=> cnt == $past(cnt) + 1'b1);
            assert_halt_hold_R1: assert property (@(posedge clk) disable iff (rst)
                (halted && !ld) |=> $stable(cnt));
            assert_load_wins_R2: assert property (@(posedge clk) disable iff (rst)
                ld |=> cnt == $past(wdata[CNT_W-1:0]));
        end else begin : g_none
            assert_no_counter_R7: assert property (@(posedge clk) disable iff (rst)
                ld |=> (cnt == '0) && !run);
        end
    endgenerate

    assert_one_event_kind_R5: assert property (@(posedge clk) disable iff (rst)
        !(sample_pulse && cycevt_pulse));
    assert_sync_gate_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_pulse) |-> $past(sync_allow) && $past(run) && !$past(halted));
    assert_pcsamp_halt_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd2 && halted) |-> reg_rdata == 32'hFFFF_FFFF);
    assert_sample_single_R9: assert property (@(posedge clk) disable iff (rst)
        sample_pulse |=> !sample_pulse);
    assert_cycevt_single_R9: assert property (@(posedge clk) disable iff (rst)
        cycevt_pulse |=> !cycevt_pulse);
endmodule

bind cyc_sampler_top cyc_sampler_chk #(.CNT_W(CNT_W), .HAS_COUNTER(HAS_COUNTER)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .halted       (core_halted),
    .run          (ctrl_q.run),
    .ld           (cnt_wr),
    .cnt          (cnt_q),
    .wdata        (reg_wdata),
    .sync_allow   (sync_allow),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .sample_pulse (sample_pulse),
    .cycevt_pulse (cycevt_pulse),
    .sync_pulse   (sync_pulse)
);

// File: tb/cyc_sampler_top_tb_top.sv
`timescale 1ns/1ps
module cyc_sampler_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_halted = 1'b0;
    logic [31:0] inst_addr = '0;
    logic        sync_allow = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rdata, rdata_nc;
    logic        s_p, c_p, y_p, s_nc, c_nc, y_nc;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    cyc_sampler_top dut_i (
        .clk(clk), .rst(rst), .core_halted(core_halted), .inst_addr(inst_addr),
        .sync_allow(sync_allow), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .sample_pulse(s_p),
        .cycevt_pulse(c_p), .sync_pulse(y_p));

    cyc_sampler_top #(.HAS_COUNTER(1'b0)) dut_nc_i (
        .clk(clk), .rst(rst), .core_halted(core_halted), .inst_addr(inst_addr),
        .sync_allow(sync_allow), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_nc), .sample_pulse(s_nc),
        .cycevt_pulse(c_nc), .sync_pulse(y_nc));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit run, input bit samp, input bit cyc,
                                       input bit taphi, input logic [1:0] sync, input logic [3:0] pre);
        return {20'd0, pre, 2'b00, sync, taphi, cyc, samp, run};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check(v == 0, "R10 ctrl", v, 0);
        rd(2'd1, v); check(v == 0, "R10 count", v, 0);
        check({s_p, c_p, y_p} == 3'b000, "R10 pulses", {29'd0, s_p, c_p, y_p}, 0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr(2'd1, 32'd0);
        wr(2'd0, mk(1, 0, 0, 0, 2'd0, 4'd0));
        repeat (10) @(negedge clk);
        rd(2'd1, v); check(v == 10, "R1 increments", v, 10);
        core_halted = 1'b1;
        repeat (5) @(negedge clk);
        rd(2'd1, v); check(v == 10, "R1 halted holds", v, 10);
        rd(2'd2, v); check(v == 32'hFFFF_FFFF, "R8 halted sample", v, 32'hFFFF_FFFF);
        core_halted = 1'b0;
        inst_addr = 32'h1234_5678;
        rd(2'd2, v); check(v == 32'h1234_5678, "R8 address sample", v, 32'h1234_5678);
        wr(2'd1, 32'hFFFF_FFFE);
        rd(2'd1, v); check(v == 32'hFFFF_FFFE, "R2 write wins", v, 32'hFFFF_FFFE);
        @(negedge clk);
        @(negedge clk);
        rd(2'd1, v); check(v == 0, "R1 wrap", v, 0);
    endtask

    task automatic t_sample_edge();
        logic [31:0] v;
        wr(2'd0, 32'd0);
        wr(2'd1, 32'h3E);
        wr(2'd0, mk(1, 1, 0, 0, 2'd0, 4'd0));
        @(negedge clk);
        rd(2'd1, v); check(v == 32'h3F && !s_p, "R9 no early pulse", {v[30:0], s_p}, 32'h7E);
        @(negedge clk);
        check(s_p == 1'b1, "R3 R9 pulse on bit6 toggle", {31'd0, s_p}, 1);
        @(negedge clk);
        check(s_p == 1'b0, "R9 single cycle", {31'd0, s_p}, 0);
    endtask

    task automatic rate(input logic [31:0] cw, input int n, input int es, input int ec, input string req);
        int ns = 0;
        int nc = 0;
        wr(2'd0, 32'd0);
        wr(2'd1, 32'd0);
        wr(2'd0, cw);
        repeat (n) begin
            @(negedge clk);
            ns += int'(s_p);
            nc += int'(c_p);
        end
        check(ns == es && nc == ec, req, (ns << 16) | nc, (es << 16) | ec);
    endtask

    task automatic t_ps_readback();
        logic [31:0] v;
        wr(2'd0, 32'd0);
        wr(2'd1, 32'h3E);
        wr(2'd0, mk(1, 1, 0, 0, 2'd0, 4'd5) | 32'h0000_F000);
        rd(2'd0, v); check(v[15:8] == 8'h55, "R4 preset load readback", {24'd0, v[15:8]}, 32'h55);
        @(negedge clk);
        @(negedge clk);
        rd(2'd0, v); check(v[15:12] == 4'd4, "R4 decrement on tap", {28'd0, v[15:12]}, 4);
    endtask

    task automatic sync_try(input logic [31:0] pre, input logic [1:0] tap, input bit allow,
                            input int exp, input string req);
        int n = 0;
        sync_allow = allow;
        wr(2'd0, 32'd0);
        wr(2'd1, pre);
        wr(2'd0, mk(1, 0, 0, 0, tap, 4'd0));
        @(negedge clk);
        n += int'(y_p);
        @(negedge clk);
        if (exp != 0) check(y_p == 1'b1, req, {31'd0, y_p}, 1);
        n += int'(y_p);
        @(negedge clk);
        n += int'(y_p);
        check(n == exp, req, n, exp);
    endtask

    task automatic t_nocounter();
        logic [31:0] v;
        wr(2'd0, mk(1, 0, 0, 0, 2'd0, 4'd0));
        reg_addr = 2'd0; #1; v = rdata_nc;
        check(v[0] == 1'b0, "R7 run reads zero", v, 0);
        repeat (4) @(negedge clk);
        reg_addr = 2'd1; #1; v = rdata_nc;
        check(v == 0, "R7 count stays zero", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count();
        t_sample_edge();
        rate(mk(1, 1, 0, 0, 2'd0, 4'd0), 512, 8, 0, "R3 R5 preset0 sample");
        rate(mk(1, 1, 0, 0, 2'd0, 4'd1), 512, 4, 0, "R4 preset1");
        rate(mk(1, 1, 0, 0, 2'd0, 4'd3), 512, 2, 0, "R4 preset3");
        rate(mk(1, 0, 1, 0, 2'd0, 4'd0), 512, 0, 8, "R5 cycle events");
        rate(mk(1, 1, 1, 0, 2'd0, 4'd0), 512, 8, 0, "R5 sample priority");
        rate(mk(1, 0, 0, 0, 2'd0, 4'd0), 512, 0, 0, "R5 both off");
        rate(mk(1, 1, 0, 1, 2'd0, 4'd0), 2048, 2, 0, "R3 bit10 tap");
        t_ps_readback();
        sync_try(32'h00FF_FFFE, 2'd1, 1'b1, 1, "R6 bit24 rise");
        sync_try(32'h1FFF_FFFE, 2'd3, 1'b1, 1, "R6 bit28 fall");
        sync_try(32'h00FF_FFFE, 2'd2, 1'b1, 0, "R6 bit26 not bit24");
        sync_try(32'h03FF_FFFE, 2'd2, 1'b1, 1, "R6 bit26 rise");
        sync_try(32'h00FF_FFFE, 2'd1, 1'b0, 0, "R6 gated by allow");
        sync_try(32'h00FF_FFFE, 2'd0, 1'b1, 0, "R6 off");
        t_nocounter();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0x00000000 expected=0x00000001");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule